// File: doc/BRIEF.md
# Discrete Signal Serial Link

This block carries twelve slow, independent logic-level signals across a cable using a single serial data line plus a forwarded bit clock. The transmit half passes each input through its own two-flop synchronizer, takes one snapshot of all twelve at the start of every frame, and shifts the frame out one bit per clock with no idle gaps. The receive half runs on the forwarded clock. It finds frame boundaries in the bit stream, checks the framing, and applies each received word to registered parallel outputs in a single update. A lock flag reports whether the stream is trusted.

Each 20-bit frame begins with five 1 bits. Three groups follow, each a 0 bit and then four data bits. The data nibbles are sent most significant first, MSB first within a nibble. A data nibble can hold at most four consecutive 1s before a 0 ends the run, so a run of five or more 1s followed by a 0 can only mark a frame start. Because frames are continuous, the serial side has no valid/ready handshake and no back-pressure: every bit clock carries one bit. The receiver cannot stall the transmitter; it can only refuse to update its outputs.

Top module: `dsl_link`

## Requirements
- R1: After reset, `sig_out` is all zeros and `locked` is low. Once locked, each output word equals a snapshot of `sig_in`.
- R2: Every input goes through two synchronizing flops. Counting edges from the first clock after reset as 1, the frame loaded at edge 20k carries the `sig_in` value present at edge 20k-2.
- R3: Transmitted bit j of a frame (j = 0..19) is 1 for j < 5 and 0 for j = 5, 10 and 15. Bits 6..9, 11..14 and 16..19 carry `sig_in[11:8]`, `[7:4]` and `[3:0]` in that order, MSB first. During reset `ser_data` is 1.
- R4: Frames follow each other every 20 clocks with no idle bits. A new snapshot is loaded at every frame start.
- R5: `ser_clk` is the transmit clock forwarded unchanged.
- R6: The receiver treats a 0 that follows at least five 1s as a frame start. It raises `locked` on a start that comes exactly 20 bits after the previous accepted start.
- R7: A 1 in any nibble-leading bit drops `locked` on that bit and discards the frame. The outputs keep their previous value.
- R8: If no frame start arrives 20 bits after the previous one, `locked` drops and the outputs hold. Two further aligned starts are needed to regain lock.
- R9: `sig_out` changes only on the last bit of a complete, error-free frame received while locked, with all twelve bits updated together.
- R10: A change on any input reaches `sig_out` within 42 bit clocks (168 ns at 250 MHz).
- R11: The output pulse width differs from the input pulse width by at most one frame (20 clocks). Pulses shorter than a frame that fall between sample points are not seen at all.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Transmit bit clock |
| rst_n | input | 1 | Transmit side asynchronous reset, active low |
| sig_in | input | 12 | Asynchronous discrete inputs |
| ser_clk | output | 1 | Forwarded bit clock |
| ser_data | output | 1 | Serial frame stream |
| rx_clk | input | 1 | Receive clock (forwarded clock at the far end) |
| rx_rst_n | input | 1 | Receive side asynchronous reset, active low |
| rx_data | input | 1 | Serial stream at the receiver |
| sig_out | output | 12 | Rebuilt discrete outputs |
| locked | output | 1 | Receiver frame lock |

## Verification
The hardest situations to reach from the ports are framing faults, because a correct transmitter never produces them. The bench therefore places a fault stage between `ser_data` and `rx_data`. In one frame it inverts a single nibble-leading bit on the wire, which must drop lock for exactly that frame and the one after. Separately, it holds the line high for ten whole frames, so that expected headers go missing and the receiver has to relock from scratch. The release point is aligned to a frame boundary, which makes the recovery cycle predictable. Directed pulses placed between and across sample points then measure latency, missed short pulses and the bound on pulse-width error.

// File: rtl/dsl_pkg.sv
package dsl_pkg;
  localparam int unsigned DEF_DATA_W  = 12;
  localparam int unsigned DEF_NIB_W   = 4;
  localparam int unsigned DEF_HDR_LEN = 5;

  // header plus one leading zero per nibble group
  function automatic int unsigned frame_len(int unsigned dw, int unsigned nw, int unsigned hl);
    return hl + (dw / nw) * (nw + 1);
  endfunction

  typedef enum logic {RX_HUNT, RX_BODY} rx_state_e;
endpackage

// File: rtl/dsl_sync.sv
module dsl_sync #(
  parameter int unsigned W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic meta, stab;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta <= 1'b0;
        stab <= 1'b0;
      end else begin
        meta <= d_async[i];
        stab <= meta;
      end
    end
    assign q[i] = stab;
  end
endmodule

// File: rtl/dsl_tx.sv
module dsl_tx
  import dsl_pkg::*;
#(
  parameter int unsigned DATA_W  = DEF_DATA_W,
  parameter int unsigned NIB_W   = DEF_NIB_W,
  parameter int unsigned HDR_LEN = DEF_HDR_LEN
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] snap,
  output logic              ser_data
);
  localparam int unsigned NIB_N     = DATA_W / NIB_W;
  localparam int unsigned FRAME_LEN = frame_len(DATA_W, NIB_W, HDR_LEN);
  localparam int unsigned CNT_W     = $clog2(FRAME_LEN);
  localparam logic [FRAME_LEN-1:0] IDLE_FRAME =
    {{HDR_LEN{1'b1}}, {(FRAME_LEN-HDR_LEN){1'b0}}};

  logic [CNT_W-1:0]     cnt;
  logic [FRAME_LEN-1:0] shreg;
  logic [FRAME_LEN-1:0] frame_w;
  logic                 last;

  assign frame_w[FRAME_LEN-1 -: HDR_LEN] = '1;
  for (genvar g = 0; g < NIB_N; g++) begin : g_grp
    localparam int unsigned SEP = FRAME_LEN - 1 - HDR_LEN - g * (NIB_W + 1);
    assign frame_w[SEP]              = 1'b0;
    assign frame_w[SEP-1 -: NIB_W]   = snap[DATA_W-1-g*NIB_W -: NIB_W];
  end

  assign last = (cnt == CNT_W'(FRAME_LEN - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      shreg <= IDLE_FRAME;
    end else if (last) begin
      cnt   <= '0;
      shreg <= frame_w;
    end else begin
      cnt   <= cnt + 1'b1;
      shreg <= {shreg[FRAME_LEN-2:0], 1'b0};
    end
  end

  assign ser_data = shreg[FRAME_LEN-1];

  // R3
  hdr_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(cnt) < HDR_LEN) |-> ser_data);
  // R3
  sep_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((int'(cnt) >= HDR_LEN) && (((int'(cnt) - HDR_LEN) % (NIB_W + 1)) == 0)) |-> !ser_data);
  // R4
  frame_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last |=> (cnt == '0) && ser_data);
endmodule

// File: rtl/dsl_rx.sv
module dsl_rx
  import dsl_pkg::*;
#(
  parameter int unsigned DATA_W  = DEF_DATA_W,
  parameter int unsigned NIB_W   = DEF_NIB_W,
  parameter int unsigned HDR_LEN = DEF_HDR_LEN
) (
  input  logic              rx_clk,
  input  logic              rx_rst_n,
  input  logic              rx_data,
  output logic [DATA_W-1:0] sig_out,
  output logic              locked
);
  localparam int unsigned FRAME_LEN = frame_len(DATA_W, NIB_W, HDR_LEN);
  localparam int unsigned BODY_LAST = FRAME_LEN - HDR_LEN - 1;
  localparam int unsigned IDX_W     = $clog2(FRAME_LEN);
  localparam int unsigned RUN_W     = $clog2(HDR_LEN + 1);
  localparam int unsigned GAP_W     = $clog2(FRAME_LEN) + 1;
  localparam logic [GAP_W-1:0] GAP_MAX  = '1;
  localparam logic [GAP_W-1:0] GAP_NEXT = GAP_W'(FRAME_LEN - 1);

  rx_state_e         state;
  logic [RUN_W-1:0]  run;
  logic [GAP_W-1:0]  gap;
  logic [IDX_W-1:0]  idx;
  logic [DATA_W-1:0] word;
  logic              have_prev;
  logic              start_w, sep_w, hdr_full;

  assign hdr_full = (run == RUN_W'(HDR_LEN));
  assign start_w  = hdr_full && !rx_data;
  assign sep_w    = ((int'(idx) % (NIB_W + 1)) == 0);

  always_ff @(posedge rx_clk or negedge rx_rst_n) begin
    if (!rx_rst_n) begin
      state     <= RX_HUNT;
      run       <= '0;
      gap       <= '0;
      idx       <= '0;
      word      <= '0;
      have_prev <= 1'b0;
      locked    <= 1'b0;
      sig_out   <= '0;
    end else begin
      run <= rx_data ? (hdr_full ? run : run + 1'b1) : '0;
      if (start_w) begin
        gap       <= '0;
        have_prev <= 1'b1;
        locked    <= have_prev && (gap == GAP_NEXT);
        state     <= RX_BODY;
        idx       <= IDX_W'(1);
      end else begin
        if (gap != GAP_MAX) gap <= gap + 1'b1;
        if (gap == GAP_NEXT) begin
          locked    <= 1'b0;
          have_prev <= 1'b0;
        end
        if (state == RX_BODY) begin
          if (sep_w) begin
            if (rx_data) begin
              locked    <= 1'b0;
              have_prev <= 1'b0;
              state     <= RX_HUNT;
            end
          end else begin
            word <= {word[DATA_W-2:0], rx_data};
          end
          if (idx == IDX_W'(BODY_LAST)) begin
            state <= RX_HUNT;
            if (locked) sig_out <= {word[DATA_W-2:0], rx_data};
          end
          idx <= idx + 1'b1;
        end
      end
    end
  end

  // R9
  out_when_locked_chk: assert property (@(posedge rx_clk) disable iff (!rx_rst_n)
    !$stable(sig_out) |-> $past(locked));
  // R9
  out_at_frame_end_chk: assert property (@(posedge rx_clk) disable iff (!rx_rst_n)
    !$stable(sig_out) |-> $past(state == RX_BODY && idx == IDX_W'(BODY_LAST)));
  // R7
  sep_err_drop_chk: assert property (@(posedge rx_clk) disable iff (!rx_rst_n)
    (state == RX_BODY && sep_w && rx_data && !start_w) |=> !locked);
  // R8
  locked_gap_chk: assert property (@(posedge rx_clk) disable iff (!rx_rst_n)
    locked |-> (gap < GAP_W'(FRAME_LEN)));
  // R6
  lock_needs_prev_chk: assert property (@(posedge rx_clk) disable iff (!rx_rst_n)
    $rose(locked) |-> $past(have_prev));
endmodule

// File: rtl/dsl_link.sv
module dsl_link
  import dsl_pkg::*;
#(
  parameter int unsigned DATA_W  = DEF_DATA_W,
  parameter int unsigned NIB_W   = DEF_NIB_W,
  parameter int unsigned HDR_LEN = DEF_HDR_LEN
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] sig_in,
  output logic              ser_clk,
  output logic              ser_data,
  input  logic              rx_clk,
  input  logic              rx_rst_n,
  input  logic              rx_data,
  output logic [DATA_W-1:0] sig_out,
  output logic              locked
);
  logic [DATA_W-1:0] snap;

  assign ser_clk = clk;

  dsl_sync #(.W(DATA_W)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (sig_in),
    .q       (snap)
  );

  dsl_tx #(.DATA_W(DATA_W), .NIB_W(NIB_W), .HDR_LEN(HDR_LEN)) u_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .snap     (snap),
    .ser_data (ser_data)
  );

  dsl_rx #(.DATA_W(DATA_W), .NIB_W(NIB_W), .HDR_LEN(HDR_LEN)) u_rx (
    .rx_clk   (rx_clk),
    .rx_rst_n (rx_rst_n),
    .rx_data  (rx_data),
    .sig_out  (sig_out),
    .locked   (locked)
  );
endmodule

// File: tb/sim_dsl_link.sv
module sim_dsl_link;
  localparam int FL      = 20;
  localparam int LAT_MAX = 2 * FL + 2;
  localparam int N_END   = 3600;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n;
  logic [11:0] sig_in;
  logic        flip, stuck;
  wire         ser_clk, ser_data, rx_data, locked;
  wire  [11:0] sig_out;

  assign rx_data = stuck ? 1'b1 : (ser_data ^ flip);

  dsl_link u0 (
    .clk(clk), .rst_n(rst_n), .sig_in(sig_in), .ser_clk(ser_clk), .ser_data(ser_data),
    .rx_clk(ser_clk), .rx_rst_n(rst_n), .rx_data(rx_data), .sig_out(sig_out), .locked(locked)
  );

  int          n_cmp = 0, n_bad = 0;
  logic [11:0] in_at [0:8191];
  bit          start_ok [0:511];
  bit          err_f [0:511];
  logic [11:0] exp_out, held;
  logic        m_lock, exp_ser;
  logic [31:0] lfsr;
  int          lat_t, rise_n, fall_n;
  bit          lat_done, pulse3_seen;

  task automatic check(bit ok, string tag, string what, int act, int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic logic exp_bit(int n);
    int k = n / FL;
    int j = n % FL;
    int pos, g, b;
    logic [11:0] d;
    d = (k >= 1) ? in_at[FL*k-2] : 12'h000;
    if (j < 5) return 1'b1;
    pos = j - 5;
    if (pos % 5 == 0) return 1'b0;
    g = pos / 5;
    b = pos % 5 - 1;
    return d[11-4*g-b];
  endfunction

  function automatic logic [11:0] pattern(int idx);
    case (idx % 7)
      0: return 12'hFFF;
      1: return 12'h000;
      2: return 12'hA5C;
      3: return 12'h5A3;
      4: return 12'h800;
      5: return 12'h001;
      default: return 12'h7FE;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not finish, actual 0 expected 1");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 512; i++) begin start_ok[i] = 1'b1; err_f[i] = 1'b0; end
    for (int i = 80; i < 90; i++) start_ok[i] = 1'b0;  // line held high
    err_f[60] = 1'b1;                                   // corrupted leading bit
    rst_n = 1'b0; sig_in = '0; flip = 1'b0; stuck = 1'b0;
    lfsr = 32'hACE1_2468; exp_out = '0; m_lock = 1'b0; held = '0;
    lat_done = 1'b0; pulse3_seen = 1'b0; lat_t = 0; rise_n = 0; fall_n = 0;
    repeat (3) @(negedge clk);
    check(sig_out == 12'h000, "R1", "sig_out in reset", int'(sig_out), 0);
    check(locked == 1'b0, "R6", "locked in reset", int'(locked), 0);
    check(ser_data == 1'b1, "R3", "ser_data in reset", int'(ser_data), 1);
    rst_n = 1'b1;
    for (int n = 1; n <= N_END; n++) begin
      @(posedge clk);
      #1;
      check(ser_clk == 1'b1, "R5", "ser_clk high phase", int'(ser_clk), 1);
      in_at[n] = sig_in;
      if (n % FL == 6) begin
        if (start_ok[n/FL])
          m_lock = (n / FL >= 1) && start_ok[n/FL-1] && !err_f[n/FL-1];
        else
          m_lock = 1'b0;
      end
      if (n % FL == 11 && err_f[n/FL]) m_lock = 1'b0;
      if (n % FL == 0 && n >= 2 * FL && m_lock) exp_out = in_at[n-22];
      exp_ser = exp_bit(n);

      @(negedge clk);
      check(ser_clk == 1'b0, "R5", "ser_clk low phase", int'(ser_clk), 0);
      check(ser_data == exp_ser, "R3 R4", $sformatf("ser_data after edge %0d", n),
            int'(ser_data), int'(exp_ser));
      check(sig_out == exp_out, "R1 R2 R9", $sformatf("sig_out after edge %0d", n),
            int'(sig_out), int'(exp_out));
      check(locked == m_lock, "R6 R7 R8", $sformatf("locked after edge %0d", n),
            int'(locked), int'(m_lock));

      // R7: corrupted frame 60 and the next one leave the outputs untouched
      if (n == 1200) held = sig_out;
      if (n == 1220) check(locked == 1'b0, "R7", "lock after bad leading bit", int'(locked), 0);
      if (n == 1255) check(sig_out == held, "R7", "outputs held after error", int'(sig_out), int'(held));
      // R8: missing headers while line is held high
      if (n == 1600) held = sig_out;
      if (n == 1620) check(locked == 1'b0, "R8", "lock after missing header", int'(locked), 0);
      if (n == 1820) check(locked == 1'b0, "R8", "no lock on first start", int'(locked), 0);
      if (n == 1830) check(locked == 1'b1, "R6", "relock on second start", int'(locked), 1);
      if (n == 1835) check(sig_out == held, "R8", "outputs held until relock", int'(sig_out), int'(held));
      // R11: short pulse between sample points
      if (n >= 2000 && n <= 2100 && sig_out[3]) pulse3_seen = 1'b1;
      if (n == 2100) check(!pulse3_seen, "R11", "short pulse missed", int'(pulse3_seen), 0);
      // R10: latency of bit 5 change present from edge 2199
      if (n > 2199 && !lat_done && sig_out[5]) begin
        lat_done = 1'b1;
        lat_t = n - 2199;
        check(lat_t <= LAT_MAX, "R10", "latency in clocks", lat_t, LAT_MAX);
      end
      if (n == 2300) check(lat_done, "R10", "bit 5 change arrived", int'(lat_done), 1);
      // R11: 47-clock pulse on bit 7
      if (n > 2400 && rise_n == 0 && sig_out[7]) rise_n = n;
      if (rise_n != 0 && fall_n == 0 && !sig_out[7]) fall_n = n;
      if (n == 2600)
        check(rise_n != 0 && fall_n > rise_n && (fall_n - rise_n) >= 47 - FL
              && (fall_n - rise_n) <= 47 + FL, "R11", "output pulse width",
              fall_n - rise_n, 47);

      // stimulus for edge n+1
      flip  = (n == 1210);
      stuck = (n >= 1600 && n < 1800);
      if (n < 400) begin
        sig_in = pattern(n / 60);
      end else if (n < 1900 || n >= 2700) begin
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
        if (lfsr[3:0] == 4'h0) sig_in[int'(lfsr[7:4]) % 12] = ~sig_in[int'(lfsr[7:4]) % 12];
      end else begin
        sig_in    = '0;
        sig_in[3] = (n >= 2000 && n < 2005);
        sig_in[5] = (n >= 2198);
        sig_in[7] = (n >= 2400 && n < 2447);
      end
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule